// File: doc/BRIEF.md
# Split direct-mapped instruction cache

This block serves instruction words to a fetch stage indexed by the program counter. It has two storage sections. The first is a pinned array for the lowest part of the address space. Software writes it through a preload port. While its enable is set, every fetch in that range hits. The second section is a direct-mapped line cache that serves all other addresses. Each line holds four instructions and has its own tag and valid bit.

Lookups are combinational. In the same cycle as the request, the block returns a hit flag and the instruction. When a request misses, a registered miss request comes up on the next clock. It carries the line address, which is the PC with the word-offset bits dropped. A separate sequencer fetches the line from memory and hands the whole line back in a single fill cycle. The miss request holds until that fill arrives.

The cache has two enable bits, one per section. Deasserting the general enable clears every valid bit and holds them clear. In the full configuration the pinned array holds 8192 words (LOW_AW=13) and the line cache has 2048 lines (LINE_AW=11). The defaults are a smaller configuration with the same structure: LOW_AW=9, LINE_AW=8 and PC_W=16.

Top module: `split_icache`

## Requirements
- R1: A request with PC below 2**LOW_AW (0 to 511 by default) and low_en=1 hits, and insn_o is the word last preloaded at that address.
- R2: A request with PC below 2**LOW_AW and low_en=0 never hits, even if the general section holds a valid line for it. It raises a miss request.
- R3: For a PC at or above 2**LOW_AW with gen_en=1, the request hits if the valid bit of the indexed line is set and the stored tag matches. PC bits [1:0] select the word, bits [LINE_AW+1:2] select the line, and the remaining upper bits form the tag. low_en has no effect on this section.
- R4: A request to the general section whose tag differs from the stored tag misses, and hit_o is 0.
- R5: While gen_en=0 the general section never hits and all valid bits are held cleared. After gen_en returns to 1, every line stays invalid until it is filled again.
- R6: A fill cycle (fill_we=1) with gen_en=1 writes all four words and the tag of the line given by fill_line, and the line hits from the next cycle. A fill cycle with gen_en=0 writes nothing that can later hit.
- R7: A line whose valid bit is clear never matches, including a PC whose tag field is all zero (PCs 512 to 1023 by default) right after reset.
- R8: A request that misses while no miss is pending and no fill is in progress raises miss_o on the next clock, with miss_line_o equal to PC>>2. While pending, miss_o and miss_line_o hold unchanged. miss_o falls on the clock after a fill cycle.
- R9: When hit_o is 0, insn_o is 0. With pc_req=0, hit_o is 0.
- R10: During and directly after reset, miss_o is 0 and no line of the general section is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_req | input | 1 | Fetch request valid |
| pc | input | PC_W | Fetch program counter (word address) |
| low_en | input | 1 | Enable for the pinned low section |
| gen_en | input | 1 | Enable for the line cache; low clears all valid bits |
| pre_we | input | 1 | Preload write strobe for the low section |
| pre_addr | input | LOW_AW | Preload word address |
| pre_data | input | INSN_W | Preload word |
| fill_we | input | 1 | Fill strobe; the whole line is written in this cycle |
| fill_line | input | PC_W-2 | Line address of the fill (PC>>2) |
| fill_data | input | 4*INSN_W | Line data, word 0 in the low bits |
| hit_o | output | 1 | Lookup hit |
| insn_o | output | INSN_W | Instruction word, 0 on no hit |
| miss_o | output | 1 | Pending line request |
| miss_line_o | output | PC_W-2 | Line address of the pending request |

## Verification
The bench looks up tag-zero PCs just above the pinned range right after reset. A design that took an all-zero stored tag as a match would report false hits there. It also fills a low-range line into the general section while low_en is clear, and it toggles gen_en over lines that were already filled. A design that let the general section serve pinned addresses, or that only masked hits without clearing the valid bits, would then hit where it must miss. The bench also changes the PC while a miss is pending, which catches a miss request whose line address follows the PC. Fills delivered with gen_en low catch a design that writes tags whenever fill_we is set.

// File: rtl/split_icache_pkg.sv
`timescale 1ns/1ps
package split_icache_pkg;
   typedef enum logic [0:0] {
      MS_IDLE = 1'b0,
      MS_WAIT = 1'b1
   } miss_state_e;

   function automatic int unsigned log2_ceil(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/icache_low_bank.sv
`timescale 1ns/1ps
module icache_low_bank #(
   parameter int AW = 9,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/icache_tag_store.sv
`timescale 1ns/1ps
module icache_tag_store #(
   parameter int IDX_W = 8,
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [TAG_W-1:0] wtag,
   input  logic [IDX_W-1:0] ridx,
   input  logic [TAG_W-1:0] rtag_cmp,
   output logic             match
);
   localparam int LINES = 1 << IDX_W;

   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_mem [LINES];

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         valid_q <= '0;
      end else if (we) begin
         valid_q[widx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (we && !clr) tag_mem[widx] <= wtag;
   end

   assign match = valid_q[ridx] && (tag_mem[ridx] == rtag_cmp);
endmodule

// File: rtl/icache_line_store.sv
`timescale 1ns/1ps
module icache_line_store #(
   parameter int IDX_W = 8,
   parameter int WORDS = 4,
   parameter int DW    = 32
) (
   input  logic                   clk,
   input  logic                   we,
   input  logic [IDX_W-1:0]       widx,
   input  logic [WORDS*DW-1:0]    wline,
   input  logic [IDX_W-1:0]       ridx,
   input  logic [$clog2(WORDS)-1:0] rsel,
   output logic [DW-1:0]          rdata
);
   localparam int LINES = 1 << IDX_W;

   logic [DW-1:0] word_rd [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_bank
      logic [DW-1:0] bank [LINES];
      always_ff @(posedge clk) begin
         if (we) bank[widx] <= wline[w*DW +: DW];
      end
      assign word_rd[w] = bank[ridx];
   end

   assign rdata = word_rd[rsel];
endmodule

// File: rtl/icache_miss_ctl.sv
`timescale 1ns/1ps
module icache_miss_ctl #(
   parameter int LA_W = 14
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            lookup_miss,
   input  logic            fill_done,
   input  logic [LA_W-1:0] line_in,
   output logic            miss_o,
   output logic [LA_W-1:0] line_o
);
   import split_icache_pkg::*;

   miss_state_e     state_q, state_d;
   logic [LA_W-1:0] line_q;

   always_comb begin
      state_d = state_q;
      case (state_q)
         MS_IDLE: if (lookup_miss && !fill_done) state_d = MS_WAIT;
         MS_WAIT: if (fill_done) state_d = MS_IDLE;
         default: state_d = MS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= MS_IDLE;
         line_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == MS_IDLE && state_d == MS_WAIT) line_q <= line_in;
      end
   end

   assign miss_o = (state_q == MS_WAIT);
   assign line_o = line_q;
endmodule

// File: rtl/split_icache.sv
`timescale 1ns/1ps
module split_icache #(
   parameter int PC_W    = 16,
   parameter int INSN_W  = 32,
   parameter int WORDS   = 4,
   parameter int LINE_AW = 8,
   parameter int LOW_AW  = 9,
   parameter bit USE_LOW = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           pc_req,
   input  logic [PC_W-1:0]                pc,
   input  logic                           low_en,
   input  logic                           gen_en,
   input  logic                           pre_we,
   input  logic [LOW_AW-1:0]              pre_addr,
   input  logic [INSN_W-1:0]              pre_data,
   input  logic                           fill_we,
   input  logic [PC_W-$clog2(WORDS)-1:0]  fill_line,
   input  logic [WORDS*INSN_W-1:0]        fill_data,
   output logic                           hit_o,
   output logic [INSN_W-1:0]              insn_o,
   output logic                           miss_o,
   output logic [PC_W-$clog2(WORDS)-1:0]  miss_line_o
);
   localparam int OFF_W = $clog2(WORDS);
   localparam int LA_W  = PC_W - OFF_W;
   localparam int TAG_W = LA_W - LINE_AW;

   initial begin
      assert (WORDS == (1 << OFF_W)) else $error("WORDS must be a power of two");
      assert (TAG_W >= 1) else $error("PC_W too small for LINE_AW");
      assert (LOW_AW < PC_W) else $error("LOW_AW must be below PC_W");
      assert (LOW_AW <= LA_W) else $error("low range wider than line address");
   end

   logic [LA_W-1:0]    pc_line;
   logic [LINE_AW-1:0] pc_idx;
   logic [TAG_W-1:0]   pc_tag;
   logic [OFF_W-1:0]   pc_word;
   logic               in_low;
   logic [INSN_W-1:0]  low_rdata;
   logic [INSN_W-1:0]  gen_rdata;
   logic               tag_match;
   logic               low_hit;
   logic               gen_hit;
   logic               fill_ok;

   assign pc_line = pc[PC_W-1:OFF_W];
   assign pc_idx  = pc_line[LINE_AW-1:0];
   assign pc_tag  = pc_line[LA_W-1:LINE_AW];
   assign pc_word = pc[OFF_W-1:0];
   assign fill_ok = fill_we && gen_en;

   if (USE_LOW) begin : g_low
      assign in_low = (pc[PC_W-1:LOW_AW] == '0);
      icache_low_bank #(
         .AW (LOW_AW),
         .DW (INSN_W)
      ) low_i (
         .clk   (clk),
         .we    (pre_we),
         .waddr (pre_addr),
         .wdata (pre_data),
         .raddr (pc[LOW_AW-1:0]),
         .rdata (low_rdata)
      );
   end else begin : g_nolow
      logic unused_pre;
      assign unused_pre = pre_we ^ (^pre_addr) ^ (^pre_data) ^ low_en;
      assign in_low     = 1'b0;
      assign low_rdata  = '0;
   end

   icache_tag_store #(
      .IDX_W (LINE_AW),
      .TAG_W (TAG_W)
   ) tags_i (
      .clk      (clk),
      .rst      (rst),
      .clr      (!gen_en),
      .we       (fill_ok),
      .widx     (fill_line[LINE_AW-1:0]),
      .wtag     (fill_line[LA_W-1:LINE_AW]),
      .ridx     (pc_idx),
      .rtag_cmp (pc_tag),
      .match    (tag_match)
   );

   icache_line_store #(
      .IDX_W (LINE_AW),
      .WORDS (WORDS),
      .DW    (INSN_W)
   ) lines_i (
      .clk   (clk),
      .we    (fill_ok),
      .widx  (fill_line[LINE_AW-1:0]),
      .wline (fill_data),
      .ridx  (pc_idx),
      .rsel  (pc_word),
      .rdata (gen_rdata)
   );

   assign low_hit = pc_req && in_low && low_en;
   assign gen_hit = pc_req && !in_low && gen_en && tag_match;
   assign hit_o   = low_hit || gen_hit;

   always_comb begin
      insn_o = '0;
      if (low_hit)      insn_o = low_rdata;
      else if (gen_hit) insn_o = gen_rdata;
   end

   icache_miss_ctl #(
      .LA_W (LA_W)
   ) miss_i (
      .clk         (clk),
      .rst         (rst),
      .lookup_miss (pc_req && !hit_o),
      .fill_done   (fill_we),
      .line_in     (pc_line),
      .miss_o      (miss_o),
      .line_o      (miss_line_o)
   );
endmodule

// File: rtl/split_icache_chk.sv
`timescale 1ns/1ps
module split_icache_chk #(
   parameter int PC_W   = 16,
   parameter int INSN_W = 32,
   parameter int WORDS  = 4,
   parameter int LOW_AW = 9
) (
   input logic                          clk,
   input logic                          rst,
   input logic                          pc_req,
   input logic [PC_W-1:0]               pc,
   input logic                          low_en,
   input logic                          gen_en,
   input logic                          fill_we,
   input logic                          hit_o,
   input logic [INSN_W-1:0]             insn_o,
   input logic                          miss_o,
   input logic [PC_W-$clog2(WORDS)-1:0] miss_line_o
);
   localparam int OFF_W = $clog2(WORDS);

   logic pc_low;
   assign pc_low = (pc[PC_W-1:LOW_AW] == '0);

   // R1
   p_low_hit_r1: assert property (@(posedge clk) disable iff (rst)
      (pc_req && low_en && pc_low) |-> hit_o);

   // R2
   p_low_off_r2: assert property (@(posedge clk) disable iff (rst)
      (pc_req && !low_en && pc_low) |-> !hit_o);

   // R5
   p_gen_off_r5: assert property (@(posedge clk) disable iff (rst)
      (!gen_en && !pc_low) |-> !hit_o);

   // R8: raise with captured line
   p_miss_set_r8: assert property (@(posedge clk) disable iff (rst)
      (pc_req && !hit_o && !miss_o && !fill_we) |=>
      (miss_o && miss_line_o == $past(pc[PC_W-1:OFF_W])));

   // R8: hold while pending
   p_miss_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (miss_o && !fill_we) |=> (miss_o && $stable(miss_line_o)));

   // R8: release after fill
   p_fill_clear_r8: assert property (@(posedge clk) disable iff (rst)
      fill_we |=> !miss_o);

   // R9
   p_nohit_zero_r9: assert property (@(posedge clk) disable iff (rst)
      (!hit_o) |-> (insn_o == '0));

   p_noreq_r9: assert property (@(posedge clk) disable iff (rst)
      (!pc_req) |-> !hit_o);

   // R10
   p_reset_r10: assert property (@(posedge clk)
      rst |=> !miss_o);
endmodule

bind split_icache split_icache_chk #(
   .PC_W   (PC_W),
   .INSN_W (INSN_W),
   .WORDS  (WORDS),
   .LOW_AW (LOW_AW)
) chk_i (
   .clk         (clk),
   .rst         (rst),
   .pc_req      (pc_req),
   .pc          (pc),
   .low_en      (low_en),
   .gen_en      (gen_en),
   .fill_we     (fill_we),
   .hit_o       (hit_o),
   .insn_o      (insn_o),
   .miss_o      (miss_o),
   .miss_line_o (miss_line_o)
);

// File: tb/split_icache_tb.sv
`timescale 1ns/1ps
module split_icache_tb_top;
   localparam int PC_W = 16;
   localparam int DW   = 32;
   localparam int LA_W = 14;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            pc_req = 1'b0;
   logic [PC_W-1:0] pc = '0;
   logic            low_en = 1'b0;
   logic            gen_en = 1'b0;
   logic            pre_we = 1'b0;
   logic [8:0]      pre_addr = '0;
   logic [DW-1:0]   pre_data = '0;
   logic            fill_we = 1'b0;
   logic [LA_W-1:0] fill_line = '0;
   logic [4*DW-1:0] fill_data = '0;
   logic            hit_o;
   logic [DW-1:0]   insn_o;
   logic            miss_o;
   logic [LA_W-1:0] miss_line_o;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   split_icache dut_i (
      .clk (clk), .rst (rst), .pc_req (pc_req), .pc (pc),
      .low_en (low_en), .gen_en (gen_en),
      .pre_we (pre_we), .pre_addr (pre_addr), .pre_data (pre_data),
      .fill_we (fill_we), .fill_line (fill_line), .fill_data (fill_data),
      .hit_o (hit_o), .insn_o (insn_o),
      .miss_o (miss_o), .miss_line_o (miss_line_o)
   );

   function automatic logic [DW-1:0] pw(input logic [8:0] a);
      return {8'hA5, 15'h0, a};
   endfunction

   function automatic logic [DW-1:0] fword(input logic [LA_W-1:0] la, input int w);
      return {4'hC, la, 12'h0, 2'(w)};
   endfunction

   function automatic logic [DW-1:0] exp_insn(input logic [PC_W-1:0] p);
      if (p < 16'd512) return pw(p[8:0]);
      return fword(p[PC_W-1:2], int'(p[1:0]));
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic setpc(input logic [PC_W-1:0] p, input logic r);
      @(posedge clk);
      #1;
      pc     = p;
      pc_req = r;
      #1;
   endtask

   task automatic preload(input logic [8:0] a);
      @(posedge clk);
      #1;
      pre_we   = 1'b1;
      pre_addr = a;
      pre_data = pw(a);
      @(posedge clk);
      #1;
      pre_we = 1'b0;
   endtask

   task automatic fill(input logic [LA_W-1:0] la);
      @(posedge clk);
      #1;
      pc_req    = 1'b0;
      fill_we   = 1'b1;
      fill_line = la;
      for (int w = 0; w < 4; w++) fill_data[w*DW +: DW] = fword(la, w);
      @(posedge clk);
      #1;
      fill_we = 1'b0;
   endtask

   // {pc, low_en, expected hit}
   localparam int NV = 13;
   localparam logic [17:0] VEC [NV] = '{
      {16'h0000, 2'b11},   // R1
      {16'h0005, 2'b11},   // R1
      {16'h01FF, 2'b11},   // R1
      {16'h0005, 2'b00},   // R2
      {16'h01FF, 2'b00},   // R2
      {16'h0200, 2'b11},   // R3
      {16'h0203, 2'b11},   // R3
      {16'h1234, 2'b11},   // R3
      {16'h1237, 2'b01},   // R3 low_en ignored
      {16'hFFFE, 2'b11},   // R3
      {16'h2234, 2'b10},   // R4
      {16'h0600, 2'b10},   // R4
      {16'h7FFC, 2'b10}    // R4
   };

   task automatic finish_run;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R10 miss in reset", {31'h0, miss_o}, 32'h0);
      rst    = 1'b0;
      low_en = 1'b1;
      gen_en = 1'b1;
      check("R10 miss after reset", {31'h0, miss_o}, 32'h0);
      setpc(16'h0200, 1'b1);
      check("R7 zero tag invalid", {31'h0, hit_o}, 32'h0);
      setpc(16'h1234, 1'b1);
      check("R10 line invalid", {31'h0, hit_o}, 32'h0);

      preload(9'd0);
      preload(9'd5);
      preload(9'd511);
      fill(14'h0080);
      fill(14'h048D);
      fill(14'h3FFF);

      for (int i = 0; i < NV; i++) begin
         logic [PC_W-1:0] p;
         p      = VEC[i][17:2];
         low_en = VEC[i][1];
         setpc(p, 1'b1);
         check($sformatf("R1-R4 table row %0d hit", i), {31'h0, hit_o}, {31'h0, VEC[i][0]});
         check($sformatf("table row %0d insn R9", i), insn_o, VEC[i][0] ? exp_insn(p) : 32'h0);
      end
      low_en = 1'b1;

      // R8 miss protocol
      fill(14'h3FFF);
      check("R8 cleared before test", {31'h0, miss_o}, 32'h0);
      setpc(16'h3000, 1'b1);
      check("R9 miss cycle hit", {31'h0, hit_o}, 32'h0);
      check("R9 miss cycle insn", insn_o, 32'h0);
      setpc(16'h5000, 1'b1);
      check("R8 miss raised", {31'h0, miss_o}, 32'h1);
      check("R8 miss line", {18'h0, miss_line_o}, 32'h0C00);
      setpc(16'h5000, 1'b1);
      check("R8 line held", {18'h0, miss_line_o}, 32'h0C00);
      check("R8 miss held", {31'h0, miss_o}, 32'h1);
      fill(14'h0C00);
      check("R8 miss released", {31'h0, miss_o}, 32'h0);
      setpc(16'h3002, 1'b1);
      check("R6 filled line hit", {31'h0, hit_o}, 32'h1);
      check("R6 filled word", insn_o, fword(14'h0C00, 2));
      setpc(16'h3000, 1'b0);
      check("R9 no request", {31'h0, hit_o}, 32'h0);

      // R2 low range never served by general section
      low_en = 1'b0;
      setpc(16'h0010, 1'b1);
      check("R2 low disabled", {31'h0, hit_o}, 32'h0);
      setpc(16'h0010, 1'b1);
      check("R2 miss raised", {31'h0, miss_o}, 32'h1);
      check("R2 miss line", {18'h0, miss_line_o}, 32'h0004);
      fill(14'h0004);
      setpc(16'h0010, 1'b1);
      check("R2 after fill still miss", {31'h0, hit_o}, 32'h0);
      low_en = 1'b1;
      fill(14'h3FFF);

      // R5 enable clears valid bits
      gen_en = 1'b0;
      setpc(16'h0200, 1'b1);
      check("R5 disabled no hit", {31'h0, hit_o}, 32'h0);
      gen_en = 1'b1;
      setpc(16'h0200, 1'b1);
      check("R5 cleared after re-enable", {31'h0, hit_o}, 32'h0);
      setpc(16'h1234, 1'b1);
      check("R5 other line cleared", {31'h0, hit_o}, 32'h0);
      setpc(16'h0005, 1'b1);
      check("R1 low unaffected", insn_o, pw(9'd5));

      // R6 fill ignored while disabled
      gen_en = 1'b0;
      fill(14'h048D);
      gen_en = 1'b1;
      setpc(16'h1234, 1'b1);
      check("R6 disabled fill ignored", {31'h0, hit_o}, 32'h0);
      fill(14'h048D);
      setpc(16'h1235, 1'b1);
      check("R6 enabled fill hit", {31'h0, hit_o}, 32'h1);
      check("R6 enabled fill word", insn_o, fword(14'h048D, 1));

      finish_run();
   end
endmodule